// File: doc/BRIEF.md
# Vectored Interrupt Controller with IRQ and FIQ Outputs

This block collects a parameterizable number of interrupt sources (64 or 128, packed into 32-bit words) and presents them to a processor as two request lines: a normal IRQ and a fast FIQ. Each source has its own enable bit, edge or level trigger mode, active polarity and a choice of which of the two lines it drives. Software can also make any source pending by writing a soft-trigger word. This is useful when it needs to replay an event that arrived while the controller was powered down.

Software reaches the block over a simple synchronous register bus. A read returns its data one cycle after the request. The bus gives software three status views: raw pending, pending and enabled on the IRQ route, and pending and enabled on the FIQ route. Pending bits are acknowledged by writing ones. A vector port returns the number of the most urgent pending IRQ source, where the lowest number wins, or all ones when no IRQ is pending. A second port returns whatever the vector port last reported. A two-bit master enable gates each output line. Inputs pass through a two-stage synchronizer before edge detection.

Top module: `intc_vector`

## Requirements
- R1: After reset, every enable, select, type and polarity bit reads 0, both output lines are low, and the vector port (0xD4) and the last-vector port (0xD0) both read 0xFFFFFFFF.
- R2: Source n is bit n mod 32 of word n/32, and words sit 4 bytes apart. The enable word at 0x10 reads back what was written. Writing ones at 0x30 sets only those enable bits, and writing ones at 0x20 clears only those enable bits.
- R3: A level-type source (bit 0 in the type word at 0x40) shows in the raw status word (0xA0) while its synchronized input is at the active level: high when its polarity bit at 0x50 is 0, low when it is 1. Writing its bit at 0xB0 leaves the raw bit set while the input stays active.
- R4: An edge-type source (type bit 1) latches a pending bit on a rising input edge when its polarity bit is 0, or on a falling edge when it is 1. An edge in the other direction sets nothing. The bit stays set after the input returns and is cleared by writing a one to the same bit position at 0xB0.
- R5: Writing ones at 0xC0 makes those sources pending in raw status, whatever their input level; writing the same ones at 0xB0 removes them.
- R6: A select bit of 1 (word at 0x00) routes a source to FIQ and a 0 routes it to IRQ. The IRQ status word at 0x80 equals raw AND enable AND NOT select, and the FIQ status word at 0x90 equals raw AND enable AND select.
- R7: A read of 0xD4 returns the lowest-numbered source set in IRQ status, or 0xFFFFFFFF when IRQ status is empty. FIQ-routed sources are never reported there.
- R8: A read of 0xD0 returns the value that the most recent read of 0xD4 returned.
- R9: Bit 0 of the master word at 0x64 enables irq_o and bit 1 enables fiq_o. Each output is registered and equals its master bit ANDed with the OR of its status word.
- R10: Read data appears on bus_rdata the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Asynchronous interrupt source inputs |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench looks for a clear that only masks a level source instead of leaving it pending, and for an edge detector that fires in the wrong direction or fires again when the polarity changes. Either fault changes the raw word that is read back. Priority is tested with two IRQ sources in different words pending at once, and with an FIQ-routed source left pending alone. A wrong encoder reports the higher number, and a routing bug reports the FIQ source instead of all ones. The bench also checks that 0xD0 follows 0xD4 across the idle code, and that clearing the master bit drops the output while the status word stays set.

// File: rtl/intc_vector.sv
module intc_vector #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int NW = NUM_SRC / 32;
  localparam int IW = $clog2(NUM_SRC);
  localparam int BW = ADDR_W - 4;
  localparam logic [BW-1:0] B_SEL = BW'(0), B_EN = BW'(1), B_ENC = BW'(2), B_ENS = BW'(3),
    B_TYP = BW'(4), B_POL = BW'(5), B_MST = BW'(6), B_IST = BW'(8), B_FST = BW'(9),
    B_RAW = BW'(10), B_CLR = BW'(11), B_SFT = BW'(12), B_VEC = BW'(13);

  logic [NUM_SRC-1:0] sel_q, en_q, type_q, pol_q, lat_q;
  logic [NUM_SRC-1:0] s1, s2, s3;
  logic [NUM_SRC-1:0] edge_ev, raw, irq_st, fiq_st, clr_m, sft_m, lat_nxt;
  logic [1:0]         master_q;
  logic [31:0]        last_q, vec_val;
  logic [IW-1:0]      vec_idx;
  logic               vec_hit;

  wire          wr     = bus_sel & bus_we;
  wire          rd     = bus_sel & ~bus_we;
  wire [BW-1:0] blk    = bus_addr[ADDR_W-1:4];
  wire [1:0]    widx   = bus_addr[3:2];
  wire          rd_vec = rd && blk == B_VEC && widx == 2'd1;

  function automatic logic [31:0] pick(input logic [NUM_SRC-1:0] v, input logic [1:0] w);
    pick = '0;
    for (int k = 0; k < NW; k++)
      if (w == 2'(k)) pick = v[k*32 +: 32];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= src_in; s2 <= s1; s3 <= s2;
    end
  end

  assign edge_ev = type_q & ((~pol_q & s2 & ~s3) | (pol_q & ~s2 & s3));
  assign raw     = lat_q | (~type_q & (s2 ^ pol_q));
  assign irq_st  = raw & en_q & ~sel_q;
  assign fiq_st  = raw & en_q & sel_q;

  always_comb begin
    clr_m = '0;
    sft_m = '0;
    for (int k = 0; k < NW; k++) begin
      if (wr && widx == 2'(k) && blk == B_CLR) clr_m[k*32 +: 32] = bus_wdata;
      if (wr && widx == 2'(k) && blk == B_SFT) sft_m[k*32 +: 32] = bus_wdata;
    end
    lat_nxt = (lat_q & ~clr_m) | edge_ev | sft_m;
  end

  always_comb begin
    vec_idx = '0;
    vec_hit = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (irq_st[i]) begin
        vec_idx = IW'(i);
        vec_hit = 1'b1;
      end
  end
  assign vec_val = vec_hit ? {{(32-IW){1'b0}}, vec_idx} : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; en_q <= '0; type_q <= '0; pol_q <= '0; lat_q <= '0;
      master_q <= '0;
    end else begin
      lat_q <= lat_nxt;
      if (wr && blk == B_MST && widx == 2'd1) master_q <= bus_wdata[1:0];
      for (int k = 0; k < NW; k++) begin
        if (wr && widx == 2'(k)) begin
          case (blk)
            B_SEL:   sel_q[k*32 +: 32]  <= bus_wdata;
            B_EN:    en_q[k*32 +: 32]   <= bus_wdata;
            B_ENC:   en_q[k*32 +: 32]   <= en_q[k*32 +: 32] & ~bus_wdata;
            B_ENS:   en_q[k*32 +: 32]   <= en_q[k*32 +: 32] | bus_wdata;
            B_TYP:   type_q[k*32 +: 32] <= bus_wdata;
            B_POL:   pol_q[k*32 +: 32]  <= bus_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      last_q    <= 32'hFFFF_FFFF;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      irq_o <= master_q[0] & (|irq_st);
      fiq_o <= master_q[1] & (|fiq_st);
      if (rd_vec) last_q <= vec_val;
      if (rd) begin
        case (blk)
          B_SEL:   bus_rdata <= pick(sel_q, widx);
          B_EN:    bus_rdata <= pick(en_q, widx);
          B_TYP:   bus_rdata <= pick(type_q, widx);
          B_POL:   bus_rdata <= pick(pol_q, widx);
          B_MST:   bus_rdata <= (widx == 2'd1) ? {30'd0, master_q} : 32'd0;
          B_IST:   bus_rdata <= pick(irq_st, widx);
          B_FST:   bus_rdata <= pick(fiq_st, widx);
          B_RAW:   bus_rdata <= pick(raw, widx);
          B_VEC:   bus_rdata <= (widx == 2'd0) ? last_q : (widx == 2'd1) ? vec_val : 32'd0;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/intc_vector_chk.sv
module intc_vector_chk #(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [1:0]         master_q,
  input logic [NUM_SRC-1:0] irq_st,
  input logic [NUM_SRC-1:0] fiq_st,
  input logic [NUM_SRC-1:0] raw,
  input logic [NUM_SRC-1:0] type_q,
  input logic [NUM_SRC-1:0] lat_q,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               rd_vec,
  input logic [31:0]        vec_val,
  input logic [31:0]        last_q
);
  wire clr0 = bus_sel && bus_we && bus_addr == ADDR_W'(12'hB0) && bus_wdata[0];

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n) !master_q[0] |=> !irq_o);
  a_r9_fiq_gate: assert property (@(posedge clk) disable iff (!rst_n) !master_q[1] |=> !fiq_o);
  a_r6_status_in_raw: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_st | fiq_st) & ~raw) == '0);
  a_r6_routes_disjoint: assert property (@(posedge clk) disable iff (!rst_n) (irq_st & fiq_st) == '0);
  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    type_q[0] && lat_q[0] && !clr0 |=> lat_q[0]);
  a_r7_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_st == '0) |-> (vec_val == 32'hFFFF_FFFF));
  a_r8_last_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vec |=> last_q == $past(vec_val));
endmodule

bind intc_vector intc_vector_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o), .master_q(master_q),
  .irq_st(irq_st), .fiq_st(fiq_st), .raw(raw), .type_q(type_q), .lat_q(lat_q),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rd_vec(rd_vec), .vec_val(vec_val), .last_q(last_q)
);

// File: tb/sim_intc_vector.sv
`timescale 1ns/1ps
module sim_intc_vector;
  localparam int N = 64;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic sel = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, fiq;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  intc_vector #(.NUM_SRC(N), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq));

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1 sel = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(posedge clk); #1 sel = 0;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic chk_out(input logic act_irq, input logic act_fiq, input logic e_irq, input logic e_fiq, input string t);
    checks++;
    if (act_irq !== e_irq || act_fiq !== e_fiq) begin
      fails++;
      $display("FAIL %s: got irq=%b fiq=%b expected irq=%b fiq=%b", t, act_irq, act_fiq, e_irq, e_fiq);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  task automatic outs(input logic e_irq, input logic e_fiq, input string t);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_out(irq, fiq, e_irq, e_fiq, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    outs(0, 0, "R1 outputs");
    rd(12'h010, 32'h0, "R1 enable0");
    rd(12'h004, 32'h0, "R1 select1");
    rd(12'h044, 32'h0, "R1 type1");
    rd(12'h050, 32'h0, "R1 polarity0");
    rd(12'h0D4, 32'hFFFF_FFFF, "R1 vector idle");
    rd(12'h0D0, 32'hFFFF_FFFF, "R1 last vector");
    // R2 enable aliases
    wr(12'h010, 32'h0000_00F0);
    rd(12'h010, 32'h0000_00F0, "R2 direct enable");
    wr(12'h030, 32'h0000_0003);
    rd(12'h010, 32'h0000_00F3, "R2 enable set");
    wr(12'h020, 32'h0000_0030);
    rd(12'h010, 32'h0000_00C3, "R2 enable clear");
    wr(12'h034, 32'h8000_0000);
    rd(12'h014, 32'h8000_0000, "R2 source 63 word1");
    rd(12'h010, 32'h0000_00C3, "R2 word0 untouched");
    wr(12'h010, 32'h0); wr(12'h014, 32'h0);
    // R3 level lines
    src[5] = 1; settle();
    rd(12'h0A0, 32'h0000_0020, "R3 level high pending");
    wr(12'h0B0, 32'h0000_0020);
    rd(12'h0A0, 32'h0000_0020, "R3 clear no lasting effect");
    wr(12'h050, 32'h0000_0020); settle();
    rd(12'h0A0, 32'h0, "R3 active low input high");
    src[5] = 0; settle();
    rd(12'h0A0, 32'h0000_0020, "R3 active low input low");
    wr(12'h050, 32'h0); settle();
    rd(12'h0A0, 32'h0, "R3 idle");
    // R4 edge lines, source 32
    wr(12'h044, 32'h1);
    src[32] = 1; settle();
    rd(12'h0A4, 32'h1, "R4 rising edge latched");
    src[32] = 0; settle();
    rd(12'h0A4, 32'h1, "R4 sticky after input low");
    wr(12'h0B4, 32'h1);
    rd(12'h0A4, 32'h0, "R4 cleared");
    wr(12'h054, 32'h1); settle();
    rd(12'h0A4, 32'h0, "R4 polarity change no edge");
    src[32] = 1; settle();
    rd(12'h0A4, 32'h0, "R4 rising ignored when negative");
    src[32] = 0; settle();
    rd(12'h0A4, 32'h1, "R4 falling edge latched");
    wr(12'h0B4, 32'h1);
    rd(12'h0A4, 32'h0, "R4 cleared falling");
    // R5 soft trigger
    wr(12'h0C0, 32'h0000_0100);
    rd(12'h0A0, 32'h0000_0100, "R5 soft pending");
    wr(12'h0B0, 32'h0000_0100);
    rd(12'h0A0, 32'h0, "R5 soft cleared");
    // R6 R7 R8 R9 routing, priority, outputs
    wr(12'h064, 32'h3);
    rd(12'h064, 32'h3, "R9 master readback");
    wr(12'h010, 32'h0000_0300);
    wr(12'h000, 32'h0000_0200);
    wr(12'h0C0, 32'h0000_0300);
    rd(12'h080, 32'h0000_0100, "R6 irq status");
    rd(12'h090, 32'h0000_0200, "R6 fiq status");
    outs(1, 1, "R9 both outputs");
    rd(12'h0D4, 32'd8, "R7 vector source 8");
    rd(12'h0D0, 32'd8, "R8 last is 8");
    wr(12'h014, 32'h0000_0100);
    wr(12'h0C4, 32'h0000_0100);
    rd(12'h0D4, 32'd8, "R7 lowest number wins");
    wr(12'h0B0, 32'h0000_0100);
    rd(12'h0D0, 32'd8, "R8 last holds before read");
    rd(12'h0D4, 32'd40, "R7 vector source 40");
    rd(12'h0D0, 32'd40, "R8 last is 40");
    wr(12'h0B4, 32'h0000_0100);
    rd(12'h0D4, 32'hFFFF_FFFF, "R7 fiq source not reported");
    rd(12'h0D0, 32'hFFFF_FFFF, "R8 last idle code");
    outs(0, 1, "R9 only fiq");
    wr(12'h064, 32'h1);
    outs(0, 0, "R9 fiq master off");
    rd(12'h090, 32'h0000_0200, "R9 status kept with master off");
    wr(12'h010, 32'h0);
    rd(12'h090, 32'h0, "R6 disabled not in status");
    rd(12'h0A0, 32'h0000_0200, "R6 raw ignores enable");
    // R10 hold
    rd(12'h000, 32'h0000_0200, "R10 select readback");
    wr(12'h000, 32'h0);
    @(negedge clk);
    checks++;
    if (rdata !== 32'h0000_0200) begin
      fails++;
      $display("FAIL R10 hold: got %h expected %h", rdata, 32'h0000_0200);
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule